// File: doc/BRIEF.md
# Real-Time Clock Alarm Repeat Controller

This block decides, once per second, whether a real-time clock alarm should fire. On every one-second tick it compares the current packed-BCD time and date against a programmed alarm time and date. A 4-bit mask chooses which fields take part in the comparison, and so sets how often the alarm can repeat: every second, every ten seconds, every minute, every ten minutes, hourly, daily, weekly, monthly or yearly. When the masked fields agree on a tick and the alarm is armed, the block emits a one-cycle alarm pulse.

An 8-bit repeat counter limits how many more times the alarm may fire. Each firing lowers it by one. In normal mode, a firing that finds the counter already at zero is the last one, and the block disarms itself. In chime mode the counter wraps from 0x00 to 0xFF and keeps counting down, and the block never disarms itself. Only software can stop a chiming alarm.

Software programs the block through a small register-style write port. A sync status output tells software when the configuration is locked. While sync reads 1, every write is dropped, except a control write that disarms the alarm. The current armed state and the remaining count are visible on status outputs.

Top module: `rtc_alarm_ctl`

## Requirements
- R1: After a synchronous reset, alm_enabled, alm_count, alm_sync and alm_pulse all read 0.
- R2: Register map on cfg_addr. Address 0 is control: bit 15 arms the alarm, bit 14 selects chime, bits 11:8 hold the mask and bits 7:0 hold the repeat count. Address 1 is the alarm time, with hours in 23:16, minutes in 15:8 and seconds in 7:0. Address 2 is the alarm date, with year in 31:24, month in 23:16, day in 15:8 and weekday in 7:0. A write is accepted while alm_sync reads 0, and its effect is visible one cycle later.
- R3: alm_pulse is high for exactly one cycle. That cycle is the one after a clock edge that samples tick=1 while the alarm is armed and the masked fields match.
- R4: Mask codes and the fields each one compares:
  - 0: nothing; the alarm fires on every tick.
  - 1: the seconds ones digit.
  - 2: seconds.
  - 3: the minutes ones digit and seconds.
  - 4: minutes and seconds.
  - 5: hours, minutes and seconds.
  - 6: weekday plus time.
  - 7: day plus time.
  - 8: month, day and time.
- R5: Mask codes 9 to 15 never match.
- R6: A firing with the repeat count non-zero lowers the count by one, and the alarm stays armed.
- R7: With chime off, a firing that finds the count at 0 still pulses, disarms the alarm and leaves the count at 0.
- R8: With chime on, a firing at count 0 sets the count to 0xFF, and the hardware never disarms the alarm.
- R9: alm_sync reads 1 whenever the alarm is armed. After the hardware disarms the alarm, alm_sync stays 1 until the next tick.
- R10: While alm_sync reads 1, writes have no effect. The one exception is a control write with bit 15 at 0, which disarms the alarm and changes nothing else.
- R11: When a disarming control write lands on the same edge as a firing tick, the pulse is still issued and the count is still updated, and the alarm ends up disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 32 | Write data |
| tick | input | 1 | One-second tick, one cycle wide |
| cur_time | input | 24 | Current time, BCD hh:mm:ss |
| cur_date | input | 32 | Current date, BCD year, month, day, weekday |
| alm_sync | output | 1 | Configuration locked |
| alm_pulse | output | 1 | Alarm event pulse |
| alm_enabled | output | 1 | Alarm armed |
| alm_count | output | 8 | Remaining repeat count |

## Verification
A software disarm and a matching tick can arrive on the same clock edge. Both try to change the armed state and the repeat count at once. The bench provokes this by raising tick with a matching time in the same cycle as a control write that clears bit 15. It then expects, one cycle later, a pulse, the count lowered by one, the alarm disarmed and sync low. A second overlap is checked separately: a hardware self-disarm starts the sync hold. The bench judges that overlap by checking that sync stays high until exactly the following tick.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  typedef enum logic [3:0] {
    MSK_SEC   = 4'd0,
    MSK_10S   = 4'd1,
    MSK_MIN   = 4'd2,
    MSK_10M   = 4'd3,
    MSK_HOUR  = 4'd4,
    MSK_DAY   = 4'd5,
    MSK_WEEK  = 4'd6,
    MSK_MONTH = 4'd7,
    MSK_YEAR  = 4'd8
  } alm_mask_e;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_TIME = 2'd1;
  localparam logic [1:0] REG_DATE = 2'd2;

  localparam int CTRL_EN_BIT    = 15;
  localparam int CTRL_CHIME_BIT = 14;
  localparam int CTRL_MASK_LO   = 8;

  typedef struct packed {
    logic [7:0] hr;
    logic [7:0] mn;
    logic [7:0] sc;
  } bcd_time_t;

  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mo;
    logic [7:0] dy;
    logic [7:0] wd;
  } bcd_date_t;
endpackage

// File: rtl/rtc_alarm_cfg.sv
module rtc_alarm_cfg
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32,
  parameter int MASK_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ok,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              chime,
  output logic [MASK_W-1:0] mask,
  output bcd_time_t         alm_time,
  output bcd_date_t         alm_date
);
  localparam int TIME_W = $bits(bcd_time_t);
  localparam int DATE_W = $bits(bcd_date_t);

  always_ff @(posedge clk) begin
    if (rst) begin
      chime    <= 1'b0;
      mask     <= '0;
      alm_time <= '0;
      alm_date <= '0;
    end else if (wr_ok) begin
      case (wr_addr)
        REG_CTRL: begin
          chime <= wr_data[CTRL_CHIME_BIT];
          mask  <= wr_data[CTRL_MASK_LO +: MASK_W];
        end
        REG_TIME: alm_time <= bcd_time_t'(wr_data[TIME_W-1:0]);
        REG_DATE: alm_date <= bcd_date_t'(wr_data[DATE_W-1:0]);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
#(
  parameter int MASK_W = 4
) (
  input  logic [MASK_W-1:0] mask,
  input  bcd_time_t         alm_time,
  input  bcd_date_t         alm_date,
  input  bcd_time_t         cur_time,
  input  bcd_date_t         cur_date,
  output logic              hit
);
  localparam int NFIELD = 4;

  logic [NFIELD-1:0] date_eq;
  logic eq_s1, eq_s, eq_m1, eq_m, eq_h, eq_t;

  for (genvar g = 0; g < NFIELD; g++) begin : g_date_cmp
    assign date_eq[g] = (alm_date[8*g +: 8] == cur_date[8*g +: 8]);
  end

  assign eq_s1 = (alm_time.sc[3:0] == cur_time.sc[3:0]);
  assign eq_s  = (alm_time.sc == cur_time.sc);
  assign eq_m1 = (alm_time.mn[3:0] == cur_time.mn[3:0]);
  assign eq_m  = (alm_time.mn == cur_time.mn);
  assign eq_h  = (alm_time.hr == cur_time.hr);
  assign eq_t  = eq_h & eq_m & eq_s;

  // date_eq bits: 0 weekday, 1 day, 2 month, 3 year
  always_comb begin
    case (mask)
      MSK_SEC:   hit = 1'b1;
      MSK_10S:   hit = eq_s1;
      MSK_MIN:   hit = eq_s;
      MSK_10M:   hit = eq_m1 & eq_s;
      MSK_HOUR:  hit = eq_m & eq_s;
      MSK_DAY:   hit = eq_t;
      MSK_WEEK:  hit = eq_t & date_eq[0];
      MSK_MONTH: hit = eq_t & date_eq[1];
      MSK_YEAR:  hit = eq_t & date_eq[1] & date_eq[2];
      default:   hit = 1'b0;
    endcase
  end

  logic unused_yr;
  assign unused_yr = date_eq[3];
endmodule

// File: rtl/rtc_alarm_rep.sv
module rtc_alarm_rep #(
  parameter int RPT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_wr,
  input  logic             ctrl_en,
  input  logic [RPT_W-1:0] ctrl_rpt,
  input  logic             sw_clear,
  input  logic             tick,
  input  logic             hit,
  input  logic             chime,
  output logic             en_q,
  output logic [RPT_W-1:0] rpt_q,
  output logic             sync_q,
  output logic             pulse_q
);
  logic             hold_q, hold_n, en_n, fire;
  logic [RPT_W-1:0] rpt_n;

  assign fire = tick & en_q & hit;

  always_comb begin
    en_n   = en_q;
    rpt_n  = rpt_q;
    hold_n = hold_q;
    if (tick) hold_n = 1'b0;
    if (fire) begin
      if (chime || rpt_q != '0) begin
        rpt_n = rpt_q - 1'b1;
      end else begin
        en_n   = 1'b0;
        hold_n = 1'b1;
      end
    end
    if (ctrl_wr) begin
      en_n  = ctrl_en;
      rpt_n = ctrl_rpt;
    end
    if (sw_clear) en_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      rpt_q   <= '0;
      hold_q  <= 1'b0;
      sync_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      en_q    <= en_n;
      rpt_q   <= rpt_n;
      hold_q  <= hold_n;
      sync_q  <= en_n | hold_n;
      pulse_q <= fire;
    end
  end
endmodule

// File: rtl/rtc_alarm_ctl.sv
module rtc_alarm_ctl
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32,
  parameter int RPT_W  = 8,
  parameter int MASK_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              tick,
  input  logic [23:0]       cur_time,
  input  logic [31:0]       cur_date,
  output logic              alm_sync,
  output logic              alm_pulse,
  output logic              alm_enabled,
  output logic [RPT_W-1:0]  alm_count
);
  logic              wr_ok, ctrl_wr, sw_clear, hit, chime_q;
  logic [MASK_W-1:0] mask_q;
  bcd_time_t         alm_time_q;
  bcd_date_t         alm_date_q;

  assign wr_ok    = cfg_we & ~alm_sync;
  assign ctrl_wr  = wr_ok & (cfg_addr == REG_CTRL);
  assign sw_clear = cfg_we & alm_sync & (cfg_addr == REG_CTRL) & ~cfg_wdata[CTRL_EN_BIT];

  rtc_alarm_cfg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_W(MASK_W)) i_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr_ok    (wr_ok),
    .wr_addr  (cfg_addr),
    .wr_data  (cfg_wdata),
    .chime    (chime_q),
    .mask     (mask_q),
    .alm_time (alm_time_q),
    .alm_date (alm_date_q)
  );

  rtc_alarm_match #(.MASK_W(MASK_W)) i_match (
    .mask     (mask_q),
    .alm_time (alm_time_q),
    .alm_date (alm_date_q),
    .cur_time (bcd_time_t'(cur_time)),
    .cur_date (bcd_date_t'(cur_date)),
    .hit      (hit)
  );

  rtc_alarm_rep #(.RPT_W(RPT_W)) i_rep (
    .clk      (clk),
    .rst      (rst),
    .ctrl_wr  (ctrl_wr),
    .ctrl_en  (cfg_wdata[CTRL_EN_BIT]),
    .ctrl_rpt (cfg_wdata[RPT_W-1:0]),
    .sw_clear (sw_clear),
    .tick     (tick),
    .hit      (hit),
    .chime    (chime_q),
    .en_q     (alm_enabled),
    .rpt_q    (alm_count),
    .sync_q   (alm_sync),
    .pulse_q  (alm_pulse)
  );
endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk #(
  parameter int RPT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic             tick,
  input logic             chime,
  input logic             alm_sync,
  input logic             alm_pulse,
  input logic             alm_enabled,
  input logic [RPT_W-1:0] alm_count
);
  // R3
  pulse_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    alm_pulse |-> ($past(tick) && $past(alm_enabled)));

  // R9
  sync_covers_en_chk: assert property (@(posedge clk) disable iff (rst)
    alm_enabled |-> alm_sync);

  // R8
  chime_keeps_en_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(chime) && $past(alm_enabled) && !$past(cfg_we)) |-> alm_enabled);

  // R7
  hw_clear_pulses_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(alm_enabled) && !alm_enabled && !$past(cfg_we)) |-> alm_pulse);

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (alm_pulse && ($past(alm_count) != '0 || $past(chime))) |->
      alm_count == RPT_W'($past(alm_count) - 1'b1));

  // R10
  locked_count_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(alm_sync) && $past(cfg_we) && !$past(tick)) |-> $stable(alm_count));
endmodule

bind rtc_alarm_ctl rtc_alarm_chk #(.RPT_W(RPT_W)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_we      (cfg_we),
  .tick        (tick),
  .chime       (chime_q),
  .alm_sync    (alm_sync),
  .alm_pulse   (alm_pulse),
  .alm_enabled (alm_enabled),
  .alm_count   (alm_count)
);

// File: tb/test_rtc_alarm_ctl.sv
module test_rtc_alarm_ctl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        tick = 1'b0;
  logic [23:0] cur_time = '0;
  logic [31:0] cur_date = '0;
  logic        alm_sync, alm_pulse, alm_enabled;
  logic [7:0]  alm_count;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  localparam logic [23:0] ATIME = 24'h233523;
  localparam logic [31:0] ADATE = 32'h06111301;

  always #4 clk = ~clk;

  rtc_alarm_ctl i_rtc_alarm_ctl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tick(tick), .cur_time(cur_time),
    .cur_date(cur_date), .alm_sync(alm_sync), .alm_pulse(alm_pulse),
    .alm_enabled(alm_enabled), .alm_count(alm_count)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl(bit en, bit chime, logic [3:0] m, logic [7:0] r);
    return {16'h0, en, chime, 2'b00, m, r};
  endfunction

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drive one tick; on return the edge has passed and the pulse is visible
  task automatic tk(logic [23:0] t, logic [31:0] d);
    @(negedge clk);
    cur_time = t; cur_date = d; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 enabled", {31'b0, alm_enabled}, 0);
    chk("R1 count", {24'b0, alm_count}, 0);
    chk("R1 sync", {31'b0, alm_sync}, 0);
    chk("R1 pulse", {31'b0, alm_pulse}, 0);
  endtask

  task automatic t_hourly;
    wr(2'd1, {8'h0, ATIME});
    wr(2'd2, ADATE);
    wr(2'd0, ctrl(1, 0, 4'd4, 8'd2));
    chk("R2 armed", {31'b0, alm_enabled}, 1);
    chk("R2 count", {24'b0, alm_count}, 2);
    chk("R9 sync armed", {31'b0, alm_sync}, 1);
    tk(24'h103524, 32'h0);
    chk("R3 no match", {31'b0, alm_pulse}, 0);
    tk(24'h103523, 32'h0);
    chk("R3 pulse", {31'b0, alm_pulse}, 1);
    @(negedge clk);
    chk("R3 one cycle", {31'b0, alm_pulse}, 0);
    chk("R6 count 1", {24'b0, alm_count}, 1);
    wr(2'd0, ctrl(1, 0, 4'd0, 8'h55));
    chk("R10 locked write", {24'b0, alm_count}, 1);
    tk(24'h113523, 32'h0);
    chk("R6 pulse", {31'b0, alm_pulse}, 1);
    chk("R6 count 0", {24'b0, alm_count}, 0);
    chk("R6 still armed", {31'b0, alm_enabled}, 1);
    tk(24'h123523, 32'h0);
    chk("R7 last pulse", {31'b0, alm_pulse}, 1);
    chk("R7 disarmed", {31'b0, alm_enabled}, 0);
    chk("R7 count", {24'b0, alm_count}, 0);
    chk("R9 hold", {31'b0, alm_sync}, 1);
    wr(2'd0, ctrl(1, 0, 4'd0, 8'h11));
    chk("R10 hold blocks", {31'b0, alm_enabled}, 0);
    tk(24'h120000, 32'h0);
    chk("R9 hold end", {31'b0, alm_sync}, 0);
    chk("R7 no pulse", {31'b0, alm_pulse}, 0);
  endtask

  task automatic t_chime;
    wr(2'd0, ctrl(1, 1, 4'd0, 8'd0));
    tk(24'h000001, 32'h0);
    chk("R8 pulse", {31'b0, alm_pulse}, 1);
    chk("R8 wrap", {24'b0, alm_count}, 32'hFF);
    chk("R8 armed", {31'b0, alm_enabled}, 1);
    tk(24'h000002, 32'h0);
    chk("R8 count FE", {24'b0, alm_count}, 32'hFE);
    wr(2'd0, 32'h0);
    chk("R10 sw disarm", {31'b0, alm_enabled}, 0);
    chk("R10 count kept", {24'b0, alm_count}, 32'hFE);
    chk("R10 sync low", {31'b0, alm_sync}, 0);
  endtask

  task automatic mask_case(string req, logic [3:0] m, logic [23:0] t, logic [31:0] d, bit exp);
    wr(2'd0, ctrl(1, 1, m, 8'd5));
    tk(t, d);
    chk(req, {31'b0, alm_pulse}, {31'b0, exp});
    wr(2'd0, 32'h0);
  endtask

  task automatic t_masks;
    mask_case("R4 every sec", 4'd0, 24'h010203, 32'h0, 1);
    mask_case("R4 10s hit", 4'd1, 24'h000013, 32'h0, 1);
    mask_case("R4 10s miss", 4'd1, 24'h000014, 32'h0, 0);
    mask_case("R4 min hit", 4'd2, 24'h012223, 32'h0, 1);
    mask_case("R4 min miss", 4'd2, 24'h012224, 32'h0, 0);
    mask_case("R4 10m hit", 4'd3, 24'h014523, 32'h0, 1);
    mask_case("R4 10m miss", 4'd3, 24'h014623, 32'h0, 0);
    mask_case("R4 day hit", 4'd5, ATIME, 32'h0, 1);
    mask_case("R4 day miss", 4'd5, 24'h223523, ADATE, 0);
    mask_case("R4 week hit", 4'd6, ATIME, 32'h99999901, 1);
    mask_case("R4 week miss", 4'd6, ATIME, 32'h06111302, 0);
    mask_case("R4 month hit", 4'd7, ATIME, 32'h99991307, 1);
    mask_case("R4 month miss", 4'd7, ATIME, 32'h06111401, 0);
    mask_case("R4 year hit", 4'd8, ATIME, 32'h99111305, 1);
    mask_case("R4 year miss", 4'd8, ATIME, 32'h06121301, 0);
    mask_case("R5 code 12", 4'd12, ATIME, ADATE, 0);
    mask_case("R5 code 15", 4'd15, ATIME, ADATE, 0);
  endtask

  task automatic t_collide;
    wr(2'd0, ctrl(1, 0, 4'd0, 8'd3));
    @(negedge clk);
    tick = 1'b1; cur_time = 24'h000009;
    cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 32'h0;
    @(negedge clk);
    tick = 1'b0; cfg_we = 1'b0;
    chk("R11 pulse", {31'b0, alm_pulse}, 1);
    chk("R11 disarmed", {31'b0, alm_enabled}, 0);
    chk("R11 count", {24'b0, alm_count}, 2);
    chk("R11 sync", {31'b0, alm_sync}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_hourly();
    t_chime();
    t_masks();
    t_collide();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule